// File: doc/BRIEF.md
# Multistage Feedforward CIC Decimator

This block lowers the sample rate of a signed sample stream by a fixed integer factor. It applies a cascaded integrator-comb response of order k, built only from adders and delay registers, with no multipliers. The block has no integrator feedback loops. The total factor is written as a product of primes, and every prime, counted with multiplicity, gets its own stage. A stage forms k chained moving sums of length p and then keeps one result in p. Each later stage is therefore enabled at a lower rate than the one before it. The default build decimates by 180 with order 3, using five stages with primes 2, 2, 3, 3 and 5, in that order.

All stages share one clock. A stage only advances when the sample strobe at its own input is high. Internal arithmetic is two's complement at the full output width. Every intermediate value may wrap, yet the final result is exact, because the true result always fits in the output width. The output width is the input width plus the smallest b for which 2^b is at least N^k. For the default build that is 23 extra bits.

Top module: `cic_nr_decim`

## Requirements
- R1: Exactly one output strobe is produced for every 180 accepted input samples, counting from reset. A sample is accepted when `in_valid_i` is high at a rising clock edge.
- R2: Output m equals the sum of h[i]·x[n−i], sampled at input index n = 180·m + 179. Here h is the length-180 all-ones boxcar convolved with itself three times. Input samples before reset count as zero.
- R3: `out_data_o` is 35 bits wide. A held constant input x settles to exactly x·5 832 000, including x = −2048, with no overflow.
- R4: While `in_valid_i` is low, `in_data_i` has no effect. No state advances. Once the pipeline has drained, `out_data_o` holds its value and `out_valid_o` stays low.
- R5: `out_valid_o` is high in the cycle that follows the 15th rising edge, counting from and including the edge that accepts sample 180·m + 179.
- R6: While `rst_ni` is low, `out_valid_o` is low. After reset, all history is cleared, and the outputs match R2 as if no earlier samples had been seen.
- R7: `out_valid_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Single clock for all stages |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 12 | Signed input sample |
| out_valid_o | output | 1 | Output sample strobe at the final rate |
| out_data_o | output | 35 | Signed full-precision filtered sample |

## Verification
The final stage can emit its decimated result in the same cycle that the first stage accepts a new input sample. Both can also coincide with an intermediate stage wrapping its keep counter. Long runs of back-to-back input strobes provoke this overlap. The outputs are then judged against a convolution over the whole input history, so a sample that is dropped or counted twice shows up as a value mismatch. Runs with idle gaps of irregular length move the overlap to other phases, and junk data is driven during every gap.

// File: rtl/cic_nr_pkg.sv
package cic_nr_pkg;

  localparam int unsigned FACTOR_W  = 8;
  localparam int unsigned MAX_STAGE = 32;

  typedef logic [MAX_STAGE*FACTOR_W-1:0] factor_list_t;

  // product of the first n factors of the list
  function automatic longint unsigned factor_product(factor_list_t f, int unsigned n);
    longint unsigned acc;
    acc = 1;
    for (int unsigned i = 0; i < n; i++) begin
      acc = acc * longint'(f[i*FACTOR_W +: FACTOR_W]);
    end
    return acc;
  endfunction

  // smallest b with 2**b >= n**k
  function automatic int unsigned growth_bits(longint unsigned n, int unsigned k);
    longint unsigned gain;
    longint unsigned pw;
    int unsigned     b;
    gain = 1;
    for (int unsigned i = 0; i < k; i++) gain = gain * n;
    pw = 1;
    b  = 0;
    while (pw < gain) begin
      pw = pw * 2;
      b  = b + 1;
    end
    return b;
  endfunction

endpackage

// File: rtl/cic_nr_boxcar.sv
module cic_nr_boxcar #(
  parameter int unsigned LEN   = 2,
  parameter int unsigned WIDTH = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [WIDTH-1:0] x_i,
  output logic                    vld_o,
  output logic signed [WIDTH-1:0] y_o
);

  localparam int unsigned TAPS = LEN - 1;

  logic signed [WIDTH-1:0] tap_q [TAPS];
  logic signed [WIDTH-1:0] tap_d [TAPS];
  logic signed [WIDTH-1:0] acc_q, acc_d;
  logic signed [WIDTH-1:0] win_sum;
  logic                    vld_q, vld_d;

  // window sum: current sample plus LEN-1 stored samples
  always_comb begin
    win_sum = x_i;
    for (int unsigned i = 0; i < TAPS; i++) begin
      win_sum = win_sum + tap_q[i];
    end
  end

  always_comb begin
    tap_d = tap_q;
    acc_d = acc_q;
    vld_d = en_i;
    if (en_i) begin
      tap_d[0] = x_i;
      for (int unsigned i = 1; i < TAPS; i++) begin
        tap_d[i] = tap_q[i-1];
      end
      acc_d = win_sum;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned i = 0; i < TAPS; i++) tap_q[i] <= '0;
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      tap_q <= tap_d;
      acc_q <= acc_d;
      vld_q <= vld_d;
    end
  end

  assign vld_o = vld_q;
  assign y_o   = acc_q;

endmodule

// File: rtl/cic_nr_stage.sv
module cic_nr_stage #(
  parameter int unsigned PRIME = 2,
  parameter int unsigned ORDER = 3,
  parameter int unsigned WIDTH = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic signed [WIDTH-1:0] dat_i,
  output logic                    vld_o,
  output logic signed [WIDTH-1:0] dat_o
);

  localparam int unsigned CNT_W = (PRIME > 2) ? $clog2(PRIME) : 1;
  localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(PRIME - 1);

  logic                    sec_vld [ORDER+1];
  logic signed [WIDTH-1:0] sec_dat [ORDER+1];

  assign sec_vld[0] = vld_i;
  assign sec_dat[0] = dat_i;

  for (genvar s = 0; s < ORDER; s++) begin : g_sec
    cic_nr_boxcar #(
      .LEN   (PRIME),
      .WIDTH (WIDTH)
    ) u_box (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (sec_vld[s]),
      .x_i   (sec_dat[s]),
      .vld_o (sec_vld[s+1]),
      .y_o   (sec_dat[s+1])
    );
  end

  // keep one filtered sample in PRIME: the one at phase PRIME-1
  logic [CNT_W-1:0] ph_q, ph_d;
  logic             at_last;

  assign at_last = (ph_q == LAST_PH);

  always_comb begin
    ph_d = ph_q;
    if (sec_vld[ORDER]) begin
      ph_d = at_last ? '0 : ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_d;
  end

  assign vld_o = sec_vld[ORDER] & at_last;
  assign dat_o = sec_dat[ORDER];

endmodule

// File: rtl/cic_nr_decim.sv
module cic_nr_decim
  import cic_nr_pkg::*;
#(
  parameter int unsigned IN_W       = 12,
  parameter int unsigned ORDER      = 3,
  parameter int unsigned NUM_STAGES = 5,
  // stage 0 in the least significant byte
  parameter logic [NUM_STAGES*FACTOR_W-1:0] PRIMES = {8'd5, 8'd3, 8'd3, 8'd2, 8'd2},
  localparam longint unsigned TOTAL_DECIM = factor_product(factor_list_t'(PRIMES), NUM_STAGES),
  localparam int unsigned     OUT_W       = IN_W + growth_bits(TOTAL_DECIM, ORDER)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  input  logic signed [IN_W-1:0] in_data_i,
  output logic                   out_valid_o,
  output logic signed [OUT_W-1:0] out_data_o
);

  localparam int unsigned LATENCY = NUM_STAGES * ORDER;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_sync_n = rst_sync_q[1];

  logic                    chain_vld [NUM_STAGES+1];
  logic signed [OUT_W-1:0] chain_dat [NUM_STAGES+1];

  assign chain_vld[0] = in_valid_i;
  assign chain_dat[0] = OUT_W'(in_data_i);

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    cic_nr_stage #(
      .PRIME (int'(PRIMES[g*FACTOR_W +: FACTOR_W])),
      .ORDER (ORDER),
      .WIDTH (OUT_W)
    ) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_sync_n),
      .vld_i (chain_vld[g]),
      .dat_i (chain_dat[g]),
      .vld_o (chain_vld[g+1]),
      .dat_o (chain_dat[g+1])
    );
  end

  assign out_valid_o = chain_vld[NUM_STAGES];
  assign out_data_o  = chain_dat[NUM_STAGES];

endmodule

// File: rtl/cic_nr_decim_chk.sv
module cic_nr_decim_chk #(
  parameter longint unsigned N     = 180,
  parameter int unsigned     LAT   = 15,
  parameter int unsigned     OUT_W = 35
) (
  input logic             clk_i,
  input logic             rst_sync_ni,
  input logic             in_valid_i,
  input logic             out_valid_i,
  input logic [OUT_W-1:0] out_data_i
);

  localparam int unsigned PH_W   = $clog2(N);
  localparam int unsigned IDLE_W = $clog2(LAT + 3);

  logic [PH_W-1:0]   phase_q;
  logic [LAT-1:0]    due_q;
  logic [IDLE_W-1:0] idle_q;
  logic              seen_full_q;
  logic              group_end;

  assign group_end = in_valid_i && (phase_q == PH_W'(N - 1));

  always_ff @(posedge clk_i or negedge rst_sync_ni) begin
    if (!rst_sync_ni) begin
      phase_q     <= '0;
      due_q       <= '0;
      idle_q      <= '0;
      seen_full_q <= 1'b0;
    end else begin
      if (in_valid_i) phase_q <= group_end ? '0 : phase_q + 1'b1;
      due_q <= {due_q[LAT-2:0], group_end};
      if (in_valid_i)                       idle_q <= '0;
      else if (idle_q != IDLE_W'(LAT + 2))  idle_q <= idle_q + 1'b1;
      if (group_end) seen_full_q <= 1'b1;
    end
  end

  // R1 / R5: one strobe per N accepted samples, LAT edges after the group end
  p_cadence_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    out_valid_i == due_q[LAT-1]);

  // R1: no output before a full group of inputs was accepted
  p_first_out_r1: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    out_valid_i |-> seen_full_q);

  // R7: strobes never adjacent
  p_no_adjacent_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    out_valid_i |=> !out_valid_i);

  // R4: drained and idle means frozen
  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (idle_q > IDLE_W'(LAT)) |-> ($stable(out_data_i) && !out_valid_i));

endmodule

bind cic_nr_decim cic_nr_decim_chk #(
  .N     (TOTAL_DECIM),
  .LAT   (LATENCY),
  .OUT_W (OUT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_sync_ni (rst_sync_n),
  .in_valid_i  (in_valid_i),
  .out_valid_i (out_valid_o),
  .out_data_i  (out_data_o)
);

// File: tb/tb_cic_nr_decim.sv
module tb_cic_nr_decim;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned IN_W  = 12;
  localparam int unsigned OUT_W = 35;
  localparam int          DECIM = 180;
  localparam int          ORD   = 3;
  localparam int          HLEN  = ORD * (DECIM - 1) + 1;
  localparam longint      GAIN  = 64'd5832000;
  localparam int          NSEG  = 5;
  // mode, value, length, gap period (0 = no gaps)
  // mode 0 constant, 1 ramp, 2 extremes alternating, 3 pseudo-random
  localparam int SEG_TAB [NSEG][4] = '{
    '{0,  2047, 720, 0},
    '{1,     0, 540, 2},
    '{2,     0, 720, 0},
    '{3,     0, 900, 3},
    '{0, -1000, 720, 0}
  };

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   in_valid = 1'b0;
  logic signed [IN_W-1:0] in_data = '0;
  logic                   out_valid;
  logic signed [OUT_W-1:0] out_data;

  cic_nr_decim dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_data_i  (in_data),
    .out_valid_o(out_valid),
    .out_data_o (out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int          n_checks = 0;
  int          n_errors = 0;
  int          nx = 0;
  int          out_cnt = 0;
  int          cyc = 0;
  int unsigned seed = 32'h1234_5678;
  int          xs [0:8191];
  longint      h [0:HLEN-1];
  longint      last_out = 0;
  logic        prev_ov = 1'b0;
  string       cur_req = "R2";

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  function automatic int next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[27:16]));
  endfunction

  function automatic int gen(input int mode, input int val, input int i);
    case (mode)
      0:       return val;
      1:       return ((i * 37) % 4096) - 2048;
      2:       return (i % 2 == 1) ? 2047 : -2048;
      default: return next_rand();
    endcase
  endfunction

  task automatic send(input int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = IN_W'(v);
    xs[nx]   = v;
    nx++;
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = IN_W'(next_rand());
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    nx       = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R6 valid low in reset", longint'(out_valid), 0);
    end
    rst_n = 1'b1;
    idle(4);
  endtask

  // model: boxcar of length DECIM convolved with itself ORD times
  initial begin
    longint tmp [0:HLEN-1];
    for (int j = 0; j < HLEN; j++) h[j] = (j < DECIM) ? 1 : 0;
    for (int r = 1; r < ORD; r++) begin
      for (int j = 0; j < HLEN; j++) begin
        tmp[j] = 0;
        for (int i = 0; i < DECIM; i++) if (j - i >= 0) tmp[j] += h[j-i];
      end
      for (int j = 0; j < HLEN; j++) h[j] = tmp[j];
    end
  end

  // output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      out_cnt = 0;
      prev_ov = 1'b0;
    end else begin
      if (out_valid) begin
        longint e;
        int     n;
        n = DECIM * out_cnt + DECIM - 1;
        e = 0;
        for (int i = 0; i < HLEN; i++) if (i <= n) e += h[i] * longint'(xs[n-i]);
        check(longint'(out_data) == e, cur_req, longint'(out_data), e);
        check(!prev_ov, "R7 adjacent strobes", 1, 0);
        last_out = longint'(out_data);
        out_cnt++;
      end
      prev_ov = out_valid;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    // reset state (R6)
    #(CLK_PERIOD * 2);
    check(out_valid == 1'b0, "R6 reset state", longint'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    check($bits(out_data) == OUT_W, "R3 output width", $bits(out_data), OUT_W);

    // table walk (R2, R4 with gaps and junk)
    for (int s = 0; s < NSEG; s++) begin
      for (int i = 0; i < SEG_TAB[s][2]; i++) begin
        send(gen(SEG_TAB[s][0], SEG_TAB[s][1], i));
        if (SEG_TAB[s][3] > 0) idle(i % SEG_TAB[s][3]);
      end
    end
    idle(30);
    check(out_cnt == nx / DECIM, "R1 output count", out_cnt, nx / DECIM);

    // full-scale negative constant (R3)
    do_reset();
    cur_req = "R3";
    for (int i = 0; i < 720; i++) send(-2048);
    idle(20);
    check(out_cnt == 4, "R3 output count", out_cnt, 4);
    check(last_out == -64'sd2048 * GAIN, "R3 dc gain", last_out, -64'sd2048 * GAIN);

    // idle with junk data: frozen output (R4)
    begin
      longint held;
      held = longint'(out_data);
      idle(40);
      check(longint'(out_data) == held, "R4 held output", longint'(out_data), held);
      check(out_cnt == 4, "R4 no extra strobe", out_cnt, 4);
    end

    // latency (R5)
    do_reset();
    cur_req = "R5";
    for (int i = 0; i < DECIM; i++) send(i - 90);
    for (int c = 1; c <= 15; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (c == 14) check(out_valid == 1'b0, "R5 early strobe", longint'(out_valid), 0);
      if (c == 15) check(out_valid == 1'b1, "R5 strobe on 15th edge", longint'(out_valid), 1);
    end
    idle(5);

    // reset mid-stream clears history (R6)
    cur_req = "R6";
    for (int i = 0; i < 300; i++) send(next_rand());
    do_reset();
    for (int i = 0; i < 400; i++) begin
      send(next_rand());
      if (i % 7 == 0) idle(1);
    end
    idle(30);
    check(out_cnt == 2, "R6 outputs after reset", out_cnt, 2);

    finish_run();
  end

endmodule